// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad shared by a set of parallel lanes. Storage is divided into word-interleaved banks, each one 32-bit word wide, so consecutive word addresses land in consecutive banks and each bank holds an equal share of the capacity. A request group arrives in one cycle and carries, for every lane, a valid bit, a word address, a read/write flag and write data.

The block works out which lanes collide inside the same bank. Lanes that read the same word share a single bank access. Lanes that ask one bank for different words are served over successive cycles, one word per bank per cycle, with all banks working in parallel. While a group is in progress the block reports busy and takes no new group. When every lane has been served it presents all read results together with a one-cycle completion pulse.

Top module: `banked_scratchpad`

## Requirements
- R1: Word address `a` maps to bank `a mod BANKS` and row `a div BANKS`, and BANKS must be 16, 32 or 64. With the default 16 banks, addresses 1, 17, 33 and 49 share bank 1.
- R2: After reset, `busy` and `done` are 0 and `rd_data` is all zero.
- R3: A group is taken on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is then high for exactly K cycles, starting with the next cycle, where K is the largest number of distinct addresses that the valid lanes send to any one bank.
- R4: `done` is high for exactly one cycle, the cycle right after the last busy cycle. A group with no valid lane gives `done` in the cycle after it is taken and never raises `busy`.
- R5: Lanes that read the same word in the same group are served by one access and add no cycle.
- R6: Inside one bank, pending distinct addresses are served one per cycle, in order of the lowest lane index that requests each. Different banks are served in the same cycle.
- R7: When several lanes of a group write the same word, the value of the highest-numbered writing lane is the one stored.
- R8: Accesses to one word in one group take effect in lane order: a reading lane returns the data written by the nearest lower-numbered writing lane of the group, or the stored value if no lower lane writes it.
- R9: A request presented while `busy` is high has no effect on storage or on the results of the group in progress.
- R10: In `rd_data`, lane i occupies bits [32*i+31 : 32*i]; a lane that is not valid or that writes returns 0 there.
- R11: Stored words keep their values across groups until written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request group is presented |
| lane_vld | input | LANES | Per-lane valid bit |
| lane_wr | input | LANES | Per-lane operation: 1 write, 0 read |
| lane_addr | input | LANES*AW | Per-lane word address, lane i at bits [AW*i +: AW] |
| lane_wdata | input | LANES*32 | Per-lane write data, lane i at bits [32*i +: 32] |
| busy | output | 1 | Group in progress; new groups refused |
| done | output | 1 | One-cycle pulse: all lane results are valid |
| rd_data | output | LANES*32 | Per-lane read results, lane i at bits [32*i +: 32] |

## Verification
A wrong bank or row split, or a faulty leader pick, shows at the ports as a busy run of the wrong length in the group that holds the collision, and as read data that belongs to another word in the next group that reads it back. Errors in lane-order merging appear in the same group's `rd_data` at the `done` pulse, or in the stored word on the next read. A leak of requests taken while busy shows only when the affected word is read back later, so the tests read it back straight after the busy group ends.

// File: rtl/spad_pkg.sv
package spad_pkg;

  localparam int WORD_W = 32;

  // Bank that a word address falls in (word interleaving).
  function automatic int unsigned bank_of(input int unsigned addr, input int unsigned banks);
    return addr % banks;
  endfunction

  // Row inside the bank for a word address.
  function automatic int unsigned row_of(input int unsigned addr, input int unsigned banks);
    return addr / banks;
  endfunction

  // Only the supported bank counts are legal.
  function automatic bit banks_legal(input int unsigned banks);
    return (banks == 16) || (banks == 32) || (banks == 64);
  endfunction

endpackage

// File: rtl/spad_lane_map.sv
module spad_lane_map #(
  parameter int LANES = 4,
  parameter int BANKS = 16,
  parameter int AW    = 8,
  parameter int BW    = 4,
  parameter int RW    = 4
) (
  input  logic [LANES*AW-1:0] addr_flat,
  output logic [LANES*BW-1:0] bank_flat,
  output logic [LANES*RW-1:0] row_flat
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bank_flat[g*BW +: BW] =
      BW'(spad_pkg::bank_of(32'(addr_flat[g*AW +: AW]), BANKS));
    assign row_flat[g*RW +: RW] =
      RW'(spad_pkg::row_of(32'(addr_flat[g*AW +: AW]), BANKS));
  end

endmodule

// File: rtl/spad_bank_pick.sv
module spad_bank_pick #(
  parameter int LANES   = 4,
  parameter int BW      = 4,
  parameter int RW      = 4,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*BW-1:0] bank_flat,
  input  logic [LANES*RW-1:0] row_flat,
  output logic [LANES-1:0]    grant,
  output logic [RW-1:0]       row_sel
);

  logic [LANES-1:0] hit;
  logic             found;

  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign hit[g] = pend[g] && (bank_flat[g*BW +: BW] == BW'(BANK_ID));
  end

  // Leader: lowest pending lane aimed at this bank.
  always_comb begin
    found   = 1'b0;
    row_sel = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && hit[i]) begin
        found   = 1'b1;
        row_sel = row_flat[i*RW +: RW];
      end
    end
  end

  // All pending lanes on the leader's word ride along.
  for (genvar g = 0; g < LANES; g++) begin : g_grant
    assign grant[g] = found && hit[g] && (row_flat[g*RW +: RW] == row_sel);
  end

endmodule

// File: rtl/spad_bank_mem.sv
module spad_bank_mem #(
  parameter int LANES = 4,
  parameter int ROWS  = 16,
  parameter int RW    = 4
) (
  input  logic                  clk,
  input  logic [LANES-1:0]      grant,
  input  logic [RW-1:0]         row_sel,
  input  logic [LANES-1:0]      wr,
  input  logic [LANES*32-1:0]   wdata,
  output logic [LANES*32-1:0]   rd_vals
);

  logic [31:0] store [ROWS];
  logic [31:0] merged;
  logic        any_wr;

  // Lane-order merge of all granted accesses to the single selected word.
  always_comb begin
    merged  = store[row_sel];
    any_wr  = 1'b0;
    rd_vals = '0;
    for (int i = 0; i < LANES; i++) begin
      if (grant[i]) begin
        if (wr[i]) begin
          merged = wdata[i*32 +: 32];
          any_wr = 1'b1;
        end else begin
          rd_vals[i*32 +: 32] = merged;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (any_wr) store[row_sel] <= merged;
  end

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES = 4,
  parameter int BANKS = 16,
  parameter int ROWS  = 16,
  localparam int AW   = $clog2(BANKS*ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LANES-1:0]    lane_vld,
  input  logic [LANES-1:0]    lane_wr,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*32-1:0] lane_wdata,
  output logic                busy,
  output logic                done,
  output logic [LANES*32-1:0] rd_data
);

  localparam int BW  = $clog2(BANKS);
  localparam int RW  = $clog2(ROWS);
  localparam int CW  = $clog2(LANES + 2);

  if (!spad_pkg::banks_legal(BANKS)) begin : g_bad_banks
    $error("banked_scratchpad: BANKS must be 16, 32 or 64");
  end

  // Latched group
  logic [LANES-1:0]    pend;
  logic [LANES-1:0]    wr_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*32-1:0] wdata_q;
  logic [LANES*32-1:0] res_q;
  logic                done_q;

  // Named internal events
  logic                accept;
  logic                accept_empty;
  logic                last_serve;
  logic [LANES-1:0]    grant_all;
  logic [LANES*32-1:0] rd_or;

  logic [LANES*BW-1:0] bank_flat;
  logic [LANES*RW-1:0] row_flat;
  logic [LANES-1:0]    bank_grant [BANKS];
  logic [LANES*32-1:0] bank_rd    [BANKS];

  assign busy         = |pend;
  assign accept       = req_valid && !busy;
  assign accept_empty = accept && (lane_vld == '0);
  assign last_serve   = busy && ((pend & ~grant_all) == '0);

  spad_lane_map #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .BW(BW), .RW(RW)) u_map (
    .addr_flat (addr_q),
    .bank_flat (bank_flat),
    .row_flat  (row_flat)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [RW-1:0] row_sel;

    spad_bank_pick #(.LANES(LANES), .BW(BW), .RW(RW), .BANK_ID(b)) u_pick (
      .pend      (pend),
      .bank_flat (bank_flat),
      .row_flat  (row_flat),
      .grant     (bank_grant[b]),
      .row_sel   (row_sel)
    );

    spad_bank_mem #(.LANES(LANES), .ROWS(ROWS), .RW(RW)) u_mem (
      .clk     (clk),
      .grant   (bank_grant[b]),
      .row_sel (row_sel),
      .wr      (wr_q),
      .wdata   (wdata_q),
      .rd_vals (bank_rd[b])
    );
  end

  always_comb begin
    grant_all = '0;
    rd_or     = '0;
    for (int b = 0; b < BANKS; b++) begin
      grant_all = grant_all | bank_grant[b];
      rd_or     = rd_or | bank_rd[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      wr_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_serve || accept_empty;
      if (accept) begin
        pend    <= lane_vld;
        wr_q    <= lane_wr;
        addr_q  <= lane_addr;
        wdata_q <= lane_wdata;
        res_q   <= '0;
      end else begin
        pend <= pend & ~grant_all;
        for (int i = 0; i < LANES; i++) begin
          if (grant_all[i] && !wr_q[i]) res_q[i*32 +: 32] <= rd_or[i*32 +: 32];
        end
      end
    end
  end

  assign done    = done_q;
  assign rd_data = res_q;

  // Busy-run length counter for the bound check.
  logic [CW-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= CW'(LANES)); // R3

  AST_SERVE_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (grant_all != '0)); // R6

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_all & ~pend) == '0); // R6

  AST_NO_INTAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend & ~$past(pend)) == '0)); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) || $past(req_valid))); // R4

endmodule

// File: tb/banked_scratchpad_test.sv
`timescale 1ns/1ps
module banked_scratchpad_test;

  localparam int LANES = 4;
  localparam int AW    = 8;

  typedef struct packed {
    logic [3:0]   v;
    logic [3:0]   w;
    logic [31:0]  a;
    logic [127:0] d;
    logic [2:0]   k;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{v:4'b1111, w:4'b1111, a:{8'd3, 8'd2, 8'd1, 8'd0},
      d:{32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_A000}, k:3'd1},
    '{v:4'b1111, w:4'b0000, a:{8'd3, 8'd2, 8'd1, 8'd0}, d:'0, k:3'd1},
    '{v:4'b1111, w:4'b1111, a:{8'd49, 8'd33, 8'd17, 8'd1},
      d:{32'h4900_0049, 32'h3300_0033, 32'h1700_0017, 32'h0100_0001}, k:3'd4},
    '{v:4'b1111, w:4'b0000, a:{8'd17, 8'd17, 8'd17, 8'd17}, d:'0, k:3'd1},
    '{v:4'b1111, w:4'b0000, a:{8'd17, 8'd1, 8'd17, 8'd1}, d:'0, k:3'd2},
    '{v:4'b1111, w:4'b1010, a:{8'd2, 8'd2, 8'd2, 8'd2},
      d:{32'h0000_00B3, 32'h0, 32'h0000_00B1, 32'h0}, k:3'd1},
    '{v:4'b1111, w:4'b0000, a:{8'd3, 8'd49, 8'd33, 8'd2}, d:'0, k:3'd2},
    '{v:4'b0000, w:4'b0000, a:'0, d:'0, k:3'd0},
    '{v:4'b0101, w:4'b0000, a:{8'd7, 8'd49, 8'd9, 8'd0}, d:'0, k:3'd1},
    '{v:4'b1111, w:4'b0011, a:{8'd33, 8'd17, 8'd48, 8'd0},
      d:{32'h0, 32'h0, 32'hC000_0048, 32'hC000_0000}, k:3'd2}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic [LANES-1:0]    lane_vld = '0;
  logic [LANES-1:0]    lane_wr = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic [LANES*32-1:0] lane_wdata = '0;
  logic                busy;
  logic                done;
  logic [LANES*32-1:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [256];

  always #2 clk = ~clk;

  banked_scratchpad uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lane_vld(lane_vld),
    .lane_wr(lane_wr), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lane-order reference for one group, independent of the design.
  task automatic model_group(input vec_t t, output logic [127:0] exp_rd);
    exp_rd = '0;
    for (int i = 0; i < LANES; i++) begin
      if (t.v[i]) begin
        if (t.w[i]) model[t.a[i*8 +: 8]] = t.d[i*32 +: 32];
        else        exp_rd[i*32 +: 32] = model[t.a[i*8 +: 8]];
      end
    end
  endtask

  task automatic run_group(input vec_t t, input int idx);
    logic [127:0] exp_rd;
    int cnt;
    int guard;
    model_group(t, exp_rd);
    @(negedge clk);
    while (busy) @(negedge clk);
    lane_vld = t.v; lane_wr = t.w; lane_addr = t.a; lane_wdata = t.d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0; guard = 0;
    while (!done && guard < 40) begin
      if (busy) cnt++;
      @(negedge clk);
      guard++;
    end
    check($sformatf("R1 R3 R6 busy cycles, vector %0d", idx), 64'(cnt), 64'(t.k));
    check($sformatf("R4 done seen, vector %0d", idx), 64'(done), 64'd1);
    for (int i = 0; i < LANES; i++)
      check($sformatf("R5 R7 R8 R10 R11 lane %0d data, vector %0d", i, idx),
            64'(rd_data[i*32 +: 32]), 64'(exp_rd[i*32 +: 32]));
    @(negedge clk);
    check($sformatf("R4 done single pulse, vector %0d", idx), 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 busy at reset", 64'(busy), 64'd0);
    check("R2 done at reset", 64'(done), 64'd0);
    check("R2 rd_data at reset", 64'(rd_data[63:0]), 64'd0);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) run_group(VECS[n], n);

    // R9: request held while a four-cycle group is in progress
    begin
      vec_t busy_grp;
      vec_t probe;
      logic [127:0] scratch;
      busy_grp = '{v:4'b1111, w:4'b1111, a:{8'd52, 8'd36, 8'd20, 8'd4},
                   d:{32'h5200_0052, 32'h3600_0036, 32'h2000_0020, 32'h0400_0004}, k:3'd4};
      model_group(busy_grp, scratch);
      @(negedge clk);
      lane_vld = busy_grp.v; lane_wr = busy_grp.w;
      lane_addr = busy_grp.a; lane_wdata = busy_grp.d;
      req_valid = 1'b1;
      @(negedge clk);
      check("R3 busy after accept", 64'(busy), 64'd1);
      lane_vld = 4'b0001; lane_wr = 4'b0001;
      lane_addr = {8'd0, 8'd0, 8'd0, 8'd4}; lane_wdata = {96'd0, 32'hDEAD_BEEF};
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      check("R9 results of busy group", 64'(rd_data), 64'd0);
      probe = '{v:4'b0001, w:4'b0000, a:{8'd0, 8'd0, 8'd0, 8'd4}, d:'0, k:3'd1};
      run_group(probe, 99);
      check("R9 stored word untouched", 64'(model[4]), 64'h0400_0004);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule